// File: doc/BRIEF.md
# Non-Posted Request Tag Tracker with Completion Timeout

This block hands out transaction tags for outgoing non-posted requests and keeps track of every request that is still waiting for its completion. Up to four requesting functions share a single pool of tags. A requester raises `req_valid` together with its function index. In the same cycle the tracker offers the lowest free tag that may currently be issued. The tag counts as outstanding from the next cycle on.

The tag leaves the outstanding set when a completion marked as the final one arrives for it. Completions for tags that are not outstanding are dropped and flagged. Each outstanding tag carries an age counter that advances on a prescaled tick. When the age reaches the limit of the selected timeout range, the tracker emits a timeout event that carries the tag and the function that owns it, and the tag is freed.

The number of tags that may be issued depends on the build size (32 or 64) and on a run-time enable for the upper half of the tags. The timeout range is chosen at run time, limited by a capability mask fixed at build time. The whole timeout mechanism can be switched off at run time.

Top module: `np_tag_tracker`

## Requirements
- R1: After reset every tag is free, `pool_empty` is 0, and `gnt_valid`, `cpl_unexp` and `tmo_valid` are 0.
- R2: While a request is pending and an eligible free tag exists, `gnt_valid` is 1 in the same cycle and `gnt_tag` is the lowest such tag. That tag is outstanding from the next cycle on.
- R3: With `ext_tag_en` low, only tags 0 to 31 are eligible. With `ext_tag_en` high and a 64-tag build, tags 0 to 63 are eligible. `pool_empty` is 1 exactly when no eligible tag is free, and a request made then receives no grant.
- R4: A completion for an outstanding tag with `cpl_last`=1 frees that tag from the next cycle on. With `cpl_last`=0 the tag stays outstanding.
- R5: A completion for a tag that is not outstanding changes no state and drives `cpl_unexp` to 1 in that same cycle.
- R6: When a grant and a final completion fall in the same cycle, both take effect. The retired tag is eligible from the next cycle on.
- R7: `tmo_sel` encodings: 0 selects the default limit, and 1, 2, 3 and 4 select ranges A, B, C and D. A range is used only if its bit is set in the capability parameter (bit 0 = A up to bit 3 = D). The capability must be one of 0001, 0010, 0011, 0110, 0111, 1110 or 1111, and any other value counts as no range supported. An encoding that is not usable selects the default limit. A timeout fires once the tag's age reaches the selected limit in ticks.
- R8: A timeout event drives `tmo_valid` with the tag in `tmo_tag` and its owner in `tmo_func`, and it frees the tag from the next cycle on.
- R9: When several tags are expired at once, they are reported one per cycle, lowest tag first.
- R10: While `tmo_disable` is 1, `tmo_valid` stays 0 whatever the ages are.
- R11: A completion whose tag is being reported as timed out in the same cycle is treated as unexpected (`cpl_unexp`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tag_en | input | 1 | Allows tags 32 and above to be issued |
| tmo_disable | input | 1 | Suppresses all timeout events |
| tmo_sel | input | 3 | Timeout range select (0 default, 1 A, 2 B, 3 C, 4 D) |
| req_valid | input | 1 | Request for a new tag |
| req_func | input | FUNC_W | Requesting function index |
| gnt_valid | output | 1 | A tag is granted this cycle |
| gnt_tag | output | TAG_W | Granted tag |
| pool_empty | output | 1 | No eligible tag is free |
| cpl_valid | input | 1 | Completion received |
| cpl_tag | input | TAG_W | Tag of the completion |
| cpl_last | input | 1 | Completion is the final one for its tag |
| cpl_unexp | output | 1 | Completion matched no outstanding tag |
| tmo_valid | output | 1 | Timeout event |
| tmo_tag | output | TAG_W | Tag that timed out |
| tmo_func | output | FUNC_W | Function that owned the timed-out tag |

## Verification
The assertions assume that `cpl_tag` always lies inside the built tag range. They also assume that the requester holds a request only while it can accept the offered tag in that cycle, so every cycle with `req_valid` and `gnt_valid` both high counts as an allocation. The stimulus drives completions only with tags below the build size. It changes `ext_tag_en`, `tmo_sel` and `tmo_disable` only between request bursts, at the falling edge. The single exception is the R11 case, where `tmo_disable` and a colliding completion are driven together on purpose.

// File: rtl/np_tag_pkg.sv
package np_tag_pkg;

  // True for the capability encodings that may be advertised.
  function automatic logic cap_legal(input logic [3:0] cap);
    case (cap)
      4'b0001, 4'b0010, 4'b0011, 4'b0110,
      4'b0111, 4'b1110, 4'b1111: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

  // Limit in ticks for the selected range; falls back to the default.
  function automatic logic [31:0] pick_limit(
    input logic [2:0]  sel,
    input logic [3:0]  cap,
    input logic [31:0] lim_a,
    input logic [31:0] lim_b,
    input logic [31:0] lim_c,
    input logic [31:0] lim_d,
    input logic [31:0] lim_def
  );
    logic [3:0] eff;
    eff = cap_legal(cap) ? cap : 4'b0000;
    case (sel)
      3'd1:    return eff[0] ? lim_a : lim_def;
      3'd2:    return eff[1] ? lim_b : lim_def;
      3'd3:    return eff[2] ? lim_c : lim_def;
      3'd4:    return eff[3] ? lim_d : lim_def;
      default: return lim_def;
    endcase
  endfunction

  // Number of tags that may be issued right now.
  function automatic int eligible_count(input logic ext_en, input int built);
    if (ext_en) return built;
    return (built < 32) ? built : 32;
  endfunction

endpackage

// File: rtl/tag_tick_gen.sv
module tag_tick_gen #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt;
      assign tick = (cnt == CW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tag_slot.sv
module tag_slot #(
  parameter int AGE_W  = 25,
  parameter int FUNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              retire,
  input  logic              tick,
  input  logic [FUNC_W-1:0] func_in,
  input  logic [AGE_W-1:0]  limit,
  output logic              busy,
  output logic [FUNC_W-1:0] func,
  output logic              expired
);
  logic [AGE_W-1:0] age;
  logic             age_full;

  assign age_full = &age;
  assign expired  = busy && (age >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      func <= '0;
      age  <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      func <= func_in;
      age  <= '0;
    end else if (retire) begin
      busy <= 1'b0;
    end else if (busy && tick && !age_full) begin
      age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/tag_lowest_pick.sv
module tag_lowest_pick #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/np_tag_tracker.sv
module np_tag_tracker
  import np_tag_pkg::*;
#(
  parameter int       NUM_TAGS  = 64,
  parameter int       NUM_FUNCS = 4,
  parameter int       TAG_W     = $clog2(NUM_TAGS),
  parameter int       FUNC_W    = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1,
  parameter int       TICK_DIV  = 250,
  parameter int       AGE_W     = 25,
  parameter logic [3:0] RANGE_CAP = 4'b1111,
  parameter int       LIM_A     = 1000,
  parameter int       LIM_B     = 50000,
  parameter int       LIM_C     = 1000000,
  parameter int       LIM_D     = 16000000,
  parameter int       LIM_DEF   = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tag_en,
  input  logic              tmo_disable,
  input  logic [2:0]        tmo_sel,
  input  logic              req_valid,
  input  logic [FUNC_W-1:0] req_func,
  output logic              gnt_valid,
  output logic [TAG_W-1:0]  gnt_tag,
  output logic              pool_empty,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic              cpl_last,
  output logic              cpl_unexp,
  output logic              tmo_valid,
  output logic [TAG_W-1:0]  tmo_tag,
  output logic [FUNC_W-1:0] tmo_func
);
  localparam logic [NUM_TAGS-1:0] ONE = {{(NUM_TAGS-1){1'b0}}, 1'b1};

  // Named internal events, visible to the bound checker.
  logic [NUM_TAGS-1:0] busy_vec;
  logic [NUM_TAGS-1:0] elig_mask;
  logic [NUM_TAGS-1:0] free_elig;
  logic [NUM_TAGS-1:0] exp_raw;
  logic [NUM_TAGS-1:0] exp_live;
  logic [NUM_TAGS-1:0] alloc_vec;
  logic [NUM_TAGS-1:0] retire_vec;
  logic [FUNC_W-1:0]   func_arr [NUM_TAGS];
  logic [AGE_W-1:0]    limit;
  logic [31:0]         limit32;
  logic                tick;
  logic                free_any;
  logic                cpl_hit;
  logic                cpl_retire;
  int                  elig_n;

  tag_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign limit32 = pick_limit(tmo_sel, RANGE_CAP, 32'(LIM_A), 32'(LIM_B),
                              32'(LIM_C), 32'(LIM_D), 32'(LIM_DEF));
  assign limit   = limit32[AGE_W-1:0];
  assign elig_n  = eligible_count(ext_tag_en, NUM_TAGS);

  always_comb begin
    for (int i = 0; i < NUM_TAGS; i++) elig_mask[i] = (i < elig_n);
  end

  assign free_elig = ~busy_vec & elig_mask;

  tag_lowest_pick #(.N(NUM_TAGS), .W(TAG_W)) u_gnt_pick (
    .vec (free_elig),
    .any (free_any),
    .idx (gnt_tag)
  );

  assign pool_empty = !free_any;
  assign gnt_valid  = req_valid && free_any;
  assign alloc_vec  = gnt_valid ? (ONE << gnt_tag) : '0;

  assign exp_live = tmo_disable ? '0 : exp_raw;

  tag_lowest_pick #(.N(NUM_TAGS), .W(TAG_W)) u_tmo_pick (
    .vec (exp_live),
    .any (tmo_valid),
    .idx (tmo_tag)
  );

  assign tmo_func = func_arr[tmo_tag];

  // A completion colliding with the tag being timed out loses.
  assign cpl_hit    = cpl_valid && busy_vec[cpl_tag] &&
                      !(tmo_valid && (tmo_tag == cpl_tag));
  assign cpl_unexp  = cpl_valid && !cpl_hit;
  assign cpl_retire = cpl_hit && cpl_last;
  assign retire_vec = (cpl_retire ? (ONE << cpl_tag) : '0) |
                      (tmo_valid  ? (ONE << tmo_tag) : '0);

  generate
    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
      tag_slot #(.AGE_W(AGE_W), .FUNC_W(FUNC_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc   (alloc_vec[t]),
        .retire  (retire_vec[t]),
        .tick    (tick),
        .func_in (req_func),
        .limit   (limit),
        .busy    (busy_vec[t]),
        .func    (func_arr[t]),
        .expired (exp_raw[t])
      );
    end
  endgenerate

  initial begin
    if (NUM_TAGS != 32 && NUM_TAGS != 64)
      $error("NUM_TAGS must be 32 or 64");
    if (LIM_DEF >= (1 << AGE_W) || LIM_D >= (1 << AGE_W))
      $error("timeout limits exceed AGE_W");
  end
endmodule

// File: rtl/np_tag_tracker_chk.sv
module np_tag_tracker_chk #(
  parameter int NUM_TAGS = 64,
  parameter int TAG_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ext_tag_en,
  input logic                tmo_disable,
  input logic                req_valid,
  input logic                gnt_valid,
  input logic [TAG_W-1:0]    gnt_tag,
  input logic                pool_empty,
  input logic                cpl_valid,
  input logic [TAG_W-1:0]    cpl_tag,
  input logic                cpl_last,
  input logic                cpl_unexp,
  input logic                tmo_valid,
  input logic [TAG_W-1:0]    tmo_tag,
  input logic [NUM_TAGS-1:0] busy_vec
);
  int lim;
  assign lim = (ext_tag_en || NUM_TAGS < 32) ? NUM_TAGS : 32;

  AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (int'(gnt_tag) < lim)); // R3

  AST_EMPTY_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty |-> !gnt_valid); // R3

  AST_GNT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> !busy_vec[gnt_tag]); // R2

  AST_GNT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && gnt_valid) |=> busy_vec[$past(gnt_tag)]); // R2

  AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_last && !cpl_unexp) |=> !busy_vec[$past(cpl_tag)]); // R4

  AST_UNEXP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_unexp |-> cpl_valid); // R5

  AST_NO_TMO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_disable |-> !tmo_valid); // R10

  AST_TMO_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_valid |-> busy_vec[tmo_tag]); // R8

  AST_TMO_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_valid |=> !busy_vec[$past(tmo_tag)]); // R8
endmodule

bind np_tag_tracker np_tag_tracker_chk #(
  .NUM_TAGS (NUM_TAGS),
  .TAG_W    (TAG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_tag_en  (ext_tag_en),
  .tmo_disable (tmo_disable),
  .req_valid   (req_valid),
  .gnt_valid   (gnt_valid),
  .gnt_tag     (gnt_tag),
  .pool_empty  (pool_empty),
  .cpl_valid   (cpl_valid),
  .cpl_tag     (cpl_tag),
  .cpl_last    (cpl_last),
  .cpl_unexp   (cpl_unexp),
  .tmo_valid   (tmo_valid),
  .tmo_tag     (tmo_tag),
  .busy_vec    (busy_vec)
);

// File: tb/test_np_tag_tracker.sv
module test_np_tag_tracker;
  localparam int N = 64, TW = 6, FW = 2;
  localparam int TA = 5, TB = 10, TC = 20, TD = 40, TDEF = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_tag_en = 1'b0, tmo_disable = 1'b1;
  logic [2:0] tmo_sel = 3'd0;
  logic req_valid = 1'b0;
  logic [FW-1:0] req_func = '0;
  logic gnt_valid, pool_empty, cpl_unexp, tmo_valid;
  logic [TW-1:0] gnt_tag, tmo_tag;
  logic [FW-1:0] tmo_func;
  logic cpl_valid = 1'b0, cpl_last = 1'b0;
  logic [TW-1:0] cpl_tag = '0;

  always #2 clk = ~clk;

  np_tag_tracker #(
    .NUM_TAGS(N), .NUM_FUNCS(4), .TICK_DIV(2), .AGE_W(12),
    .RANGE_CAP(4'b0011), .LIM_A(TA), .LIM_B(TB), .LIM_C(TC),
    .LIM_D(TD), .LIM_DEF(TDEF)
  ) i_np_tag_tracker (
    .clk(clk), .rst_n(rst_n), .ext_tag_en(ext_tag_en),
    .tmo_disable(tmo_disable), .tmo_sel(tmo_sel),
    .req_valid(req_valid), .req_func(req_func),
    .gnt_valid(gnt_valid), .gnt_tag(gnt_tag), .pool_empty(pool_empty),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_last(cpl_last),
    .cpl_unexp(cpl_unexp), .tmo_valid(tmo_valid), .tmo_tag(tmo_tag),
    .tmo_func(tmo_func)
  );

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Scoreboard of expected timeout events.
  typedef struct { int tag; int func; int gcyc; int lo; int hi; } exp_t;
  exp_t sbq[$];
  exp_t cur;

  always begin
    @(negedge clk);
    #2;
    if (rst_n && tmo_valid) begin
      if (sbq.size() == 0) begin
        chk(0, "R10", "unexpected timeout event tag", int'(tmo_tag), -1);
      end else begin
        cur = sbq.pop_front();
        chk(int'(tmo_tag) == cur.tag, "R9", "timeout tag order", int'(tmo_tag), cur.tag);
        chk(int'(tmo_func) == cur.func, "R8", "timeout function", int'(tmo_func), cur.func);
        chk((cyc - cur.gcyc) >= cur.lo && (cyc - cur.gcyc) <= cur.hi,
            "R7", "timeout delay cycles", cyc - cur.gcyc, cur.lo);
      end
    end
  end

  task automatic push_exp(input int tag, input int func, input int g, input int thr);
    exp_t e;
    e.tag = tag; e.func = func; e.gcyc = g;
    e.lo = 2 * thr - 2; e.hi = 2 * thr + 4;
    sbq.push_back(e);
  endtask

  task automatic do_req(input int f, input bit ev, input int et,
                        input string rq, output int g);
    @(negedge clk);
    req_valid = 1'b1;
    req_func  = FW'(f);
    #1;
    chk(gnt_valid == ev, rq, "grant valid", int'(gnt_valid), int'(ev));
    if (ev) chk(int'(gnt_tag) == et, rq, "granted tag", int'(gnt_tag), et);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    g = cyc;
  endtask

  task automatic do_cpl(input int tag, input bit last, input bit eu, input string rq);
    @(negedge clk);
    cpl_valid = 1'b1;
    cpl_tag   = TW'(tag);
    cpl_last  = last;
    #1;
    chk(cpl_unexp == eu, rq, "unexpected completion flag", int'(cpl_unexp), int'(eu));
    @(posedge clk);
    #1;
    cpl_valid = 1'b0;
    cpl_last  = 1'b0;
  endtask

  task automatic wait_sb(input string rq);
    for (int k = 0; k < 400 && sbq.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, rq, "pending expected timeouts", sbq.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "R1", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(pool_empty == 1'b0, "R1", "pool_empty after reset", int'(pool_empty), 0);
    chk(gnt_valid == 1'b0, "R1", "gnt_valid after reset", int'(gnt_valid), 0);
    chk(tmo_valid == 1'b0, "R1", "tmo_valid after reset", int'(tmo_valid), 0);
    chk(cpl_unexp == 1'b0, "R1", "cpl_unexp after reset", int'(cpl_unexp), 0);

    // R5: completions for tags never issued
    do_cpl(3, 1'b1, 1'b1, "R5");
    do_cpl(3, 1'b0, 1'b1, "R5");

    // R2/R3: lowest-first grants limited to 0..31
    for (int i = 0; i < 32; i++) do_req(i % 4, 1'b1, i, "R2", g);
    @(negedge clk); #1;
    chk(pool_empty == 1'b1, "R3", "pool_empty with ext tags off", int'(pool_empty), 1);
    do_req(0, 1'b0, 0, "R3", g);

    // R3: upper tags become eligible
    @(negedge clk);
    ext_tag_en = 1'b1;
    #1;
    chk(pool_empty == 1'b0, "R3", "pool_empty with ext tags on", int'(pool_empty), 0);
    for (int i = 32; i < 64; i++) do_req(1, 1'b1, i, "R3", g);
    @(negedge clk); #1;
    chk(pool_empty == 1'b1, "R3", "pool_empty when all 64 used", int'(pool_empty), 1);

    // R4: non-final completion keeps the tag
    do_cpl(5, 1'b0, 1'b0, "R4");
    @(negedge clk); #1;
    chk(pool_empty == 1'b1, "R4", "tag kept after non-last", int'(pool_empty), 1);
    do_cpl(5, 1'b1, 1'b0, "R4");
    do_cpl(7, 1'b1, 1'b0, "R4");

    // R6: grant and retire in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_func = 2'd2;
    cpl_valid = 1'b1; cpl_tag = 6'd9; cpl_last = 1'b1;
    #1;
    chk(int'(gnt_tag) == 5, "R6", "grant beside retire", int'(gnt_tag), 5);
    chk(cpl_unexp == 1'b0, "R6", "retire beside grant", int'(cpl_unexp), 0);
    @(posedge clk); #1;
    req_valid = 1'b0; cpl_valid = 1'b0; cpl_last = 1'b0;
    do_req(0, 1'b1, 7, "R6", g);
    do_req(0, 1'b1, 9, "R6", g);
    do_req(0, 1'b0, 0, "R3", g);

    // Timeout phase
    do_reset();
    ext_tag_en  = 1'b0;
    tmo_sel     = 3'd1;
    tmo_disable = 1'b0;
    // R9: four tags granted back to back, reported lowest first
    for (int i = 0; i < 4; i++) begin
      do_req(3 - i, 1'b1, i, "R9", g);
      push_exp(i, 3 - i, g, TA);
    end
    wait_sb("R9");

    // R7: range C not in capability -> default limit
    @(negedge clk); tmo_sel = 3'd3;
    do_req(2, 1'b1, 0, "R8", g);
    push_exp(0, 2, g, TDEF);
    wait_sb("R7");

    // R7: range B supported
    @(negedge clk); tmo_sel = 3'd2;
    do_req(1, 1'b1, 0, "R7", g);
    push_exp(0, 1, g, TB);
    wait_sb("R7");

    // R10: no timeout while disabled
    @(negedge clk); tmo_disable = 1'b1;
    do_req(1, 1'b1, 0, "R10", g);
    do_req(2, 1'b1, 1, "R10", g);
    repeat (120) @(negedge clk);
    #1;
    chk(tmo_valid == 1'b0, "R10", "tmo_valid while disabled", int'(tmo_valid), 0);

    // R11: re-enable with a completion colliding on the reported tag
    begin
      exp_t e;
      e.tag = 0; e.func = 1; e.gcyc = 0; e.lo = 0; e.hi = 1000000;
      sbq.push_back(e);
      e.tag = 1; e.func = 2;
      sbq.push_back(e);
    end
    @(negedge clk);
    tmo_disable = 1'b0;
    cpl_valid = 1'b1; cpl_tag = 6'd0; cpl_last = 1'b1;
    #1;
    chk(tmo_valid == 1'b1 && tmo_tag == 6'd0, "R11", "timeout reported tag",
        int'(tmo_tag), 0);
    chk(cpl_unexp == 1'b1, "R11", "colliding completion flagged", int'(cpl_unexp), 1);
    @(posedge clk); #1;
    cpl_valid = 1'b0; cpl_last = 1'b0;
    wait_sb("R11");

    @(negedge clk); tmo_disable = 1'b1;
    do_req(0, 1'b1, 0, "R8", g);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule